// File: doc/BRIEF.md
# Expansion Memory-Security Interrupt Controller

This register slice gathers the interrupt levels raised by up to sixteen memory security checkers on the expansion side of a chip. It presents those levels as a status word, ANDs the word with a software-written enable mask and drives a single combined interrupt. Each checker also receives a clear line and a non-secure configuration line. Both lines come from the same register slice.

Software reaches the slice through a plain 32-bit write/read port with a 12-bit byte address. Checker `n` always sits at register bit `n+16`, and bits 15:0 of the status word read as zero. A write to the clear register does not latch and then release. It sets the level of every clear line to the written upper half, and the lines keep that level until the next clear write. The combined interrupt is combinational. It follows the checker inputs in the same cycle and follows a new enable value from the cycle after the write.

Top module: `msc_irq_ctrl`

## Requirements
- R1: Reading offset 0x030 returns checker input `n` in bit `n+16`, with all other bits zero, in the same cycle as the inputs. Address bits 1:0 are ignored on every access.
- R2: The status register is read-only: a write to 0x030 changes no register, output or later read value.
- R3: `irq_out` is high exactly when some bit of (status word AND enable register) is set. It changes in the same cycle as a checker input, and enable bits 15:0 never raise it.
- R4: A write to 0x038 stores all 32 bits of `reg_wdata` in the enable register. From the next cycle the stored value reads back at 0x038 and takes part in `irq_out`.
- R5: A write to 0x034 drives `chk_clr_out[n]` with `reg_wdata[n+16]` from the next cycle. The level holds until the next write to 0x034. Reading 0x034 returns zero.
- R6: A write to 0x0D0 stores all 32 bits of `reg_wdata` and reads them back at 0x0D0. From the next cycle `chk_ns_out[n]` equals stored bit `n+16`.
- R7: A clock edge with `rst_n` low clears the enable register, the non-secure register and the clear outputs. The status read and `irq_out` inputs keep tracking the checkers during reset.
- R8: Reads of any offset other than 0x030, 0x038 and 0x0D0 return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 12 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chk_irq_in | input | NUM_CHK | Interrupt level from each checker |
| chk_clr_out | output | NUM_CHK | Clear level to each checker |
| chk_ns_out | output | NUM_CHK | Non-secure configuration to each checker |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a set of enable bits that look live but sit in the lower half of the word. They are stored and read back, yet they must never raise the interrupt, because no checker maps there. The stimulus writes such masks while checker inputs are active and checks that the interrupt stays low. A second hard case is checker activity during a mid-run reset, where the stored registers clear but status must keep following the inputs. The stimulus toggles the inputs while reset is held with all registers loaded. A long random phase then mixes writes to every mapped and unmapped offset with input changes, and the bench model is compared on every cycle.

// File: rtl/msc_pkg.sv
// Shared constants and the register selector for the expansion
// memory-security interrupt controller. Assumes 12-bit byte addresses
// and word-aligned registers; address bits 1:0 play no part.
package msc_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int BIT_BASE = 16;   // checker n sits at register bit n+BIT_BASE

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_NSCFG  = 12'h0D0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_ENABLE,
        SEL_NSCFG
    } reg_sel_e;

    // Map a byte address onto the register it selects.
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (addr[ADDR_W-1:2] == OFS_STATUS[ADDR_W-1:2]) sel = SEL_STATUS;
        if (addr[ADDR_W-1:2] == OFS_CLEAR[ADDR_W-1:2])  sel = SEL_CLEAR;
        if (addr[ADDR_W-1:2] == OFS_ENABLE[ADDR_W-1:2]) sel = SEL_ENABLE;
        if (addr[ADDR_W-1:2] == OFS_NSCFG[ADDR_W-1:2])  sel = SEL_NSCFG;
        return sel;
    endfunction

endpackage

// File: rtl/msc_status_map.sv
// Places the checker interrupt levels into the status word at bit n+16.
// Purely combinational, so it tracks the inputs during reset too.
// Assumes 1 <= NUM_CHK <= 16.
module msc_status_map
    import msc_pkg::*;
#(
    parameter int NUM_CHK = 16
) (
    input  logic [NUM_CHK-1:0] chk_irq_in,
    output logic [DATA_W-1:0]  status_word
);
    localparam int TOP_BIT = BIT_BASE + NUM_CHK;

    // Lower half never carries a checker.
    assign status_word[BIT_BASE-1:0] = '0;

    // One status bit per checker.
    for (genvar i = 0; i < NUM_CHK; i++) begin : g_map
        assign status_word[BIT_BASE+i] = chk_irq_in[i];
    end

    // Bits above the last checker read zero.
    if (TOP_BIT < DATA_W) begin : g_pad
        assign status_word[DATA_W-1:TOP_BIT] = '0;
    end

endmodule

// File: rtl/msc_ctrl_regs.sv
// Holds the enable mask, the non-secure configuration word and the
// clear-line levels. All three load on a write strobe to their own
// selector and clear on a synchronous active-low reset.
module msc_ctrl_regs
    import msc_pkg::*;
#(
    parameter int NUM_CHK = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  en_q,
    output logic [DATA_W-1:0]  ns_q,
    output logic [NUM_CHK-1:0] clr_q
);

    // Register update: reset, then one selected register per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            ns_q  <= '0;
            clr_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: en_q  <= wdata;
                SEL_NSCFG:  ns_q  <= wdata;
                SEL_CLEAR:  clr_q <= wdata[BIT_BASE +: NUM_CHK];
                default: ;
            endcase
        end
    end

    // R7: reset leaves every stored value at zero.
    p_rst_zero_r7: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && ns_q == '0 && clr_q == '0));

    // R4: enable captures the full written word.
    p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_ENABLE) |=> en_q == $past(wdata));

    // R5: clear lines hold between clear writes.
    p_clr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_CLEAR) |=> $stable(clr_q));

    // R2 and R8: status or unmapped writes touch no stored value.
    p_no_side_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_STATUS || sel == SEL_NONE))
        |=> ($stable(en_q) && $stable(ns_q) && $stable(clr_q)));

endmodule

// File: rtl/msc_read_mux.sv
// Selects the read word for the addressed register. Clear and unmapped
// offsets return zero. Combinational; no read strobe.
module msc_read_mux
    import msc_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] en_q,
    input  logic [DATA_W-1:0] ns_q,
    output logic [DATA_W-1:0] rdata
);

    // Read-data selection.
    always_comb begin
        case (sel)
            SEL_STATUS: rdata = status_word;
            SEL_ENABLE: rdata = en_q;
            SEL_NSCFG:  rdata = ns_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/msc_irq_ctrl.sv
// Top of the expansion memory-security interrupt controller. Decodes the
// register port, builds the status word, keeps the control registers and
// combines status with enable into one level interrupt. Assumes one
// write per cycle with reg_wr high and 1 <= NUM_CHK <= 16.
module msc_irq_ctrl
    import msc_pkg::*;
#(
    parameter int NUM_CHK = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_CHK-1:0] chk_irq_in,
    output logic [NUM_CHK-1:0] chk_clr_out,
    output logic [NUM_CHK-1:0] chk_ns_out,
    output logic               irq_out
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ns_q;

    // Address decode shared by reads and writes.
    assign sel = decode_sel(reg_addr);

    msc_status_map #(.NUM_CHK(NUM_CHK)) u_status (
        .chk_irq_in  (chk_irq_in),
        .status_word (status_word)
    );

    msc_ctrl_regs #(.NUM_CHK(NUM_CHK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .sel   (sel),
        .wdata (reg_wdata),
        .en_q  (en_q),
        .ns_q  (ns_q),
        .clr_q (chk_clr_out)
    );

    msc_read_mux u_rmux (
        .sel         (sel),
        .status_word (status_word),
        .en_q        (en_q),
        .ns_q        (ns_q),
        .rdata       (reg_rdata)
    );

    // Combined interrupt: any enabled, active checker.
    assign irq_out = |(status_word & en_q);

    // Non-secure lines follow the upper half of the stored word.
    assign chk_ns_out = ns_q[BIT_BASE +: NUM_CHK];

    // R3: with no active checker the interrupt stays low.
    p_irq_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_irq_in == '0) |-> !irq_out);

    // R3: an enabled active checker always raises the interrupt.
    p_irq_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chk_irq_in & en_q[BIT_BASE +: NUM_CHK])) |-> irq_out);

    // R1: a status read shows the checker inputs at bit n+16.
    p_status_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STATUS) |-> reg_rdata[BIT_BASE +: NUM_CHK] == chk_irq_in);

    // R6: non-secure lines change only after a write to their register.
    p_ns_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && sel == SEL_NSCFG) |=> $stable(chk_ns_out));

endmodule

// File: tb/test_msc_irq_ctrl.sv
module test_msc_irq_ctrl;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = 12'h000;
    logic [31:0]   reg_wdata = 32'h0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  chk_irq_in = '0;
    logic [N-1:0]  chk_clr_out;
    logic [N-1:0]  chk_ns_out;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Reference state, kept behaviourally.
    logic [31:0]  m_en = 32'h0;
    logic [31:0]  m_ns = 32'h0;
    logic [N-1:0] m_clr = '0;

    always #5 clk = ~clk;   // 100 MHz

    msc_irq_ctrl #(.NUM_CHK(N)) i_msc_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .chk_irq_in  (chk_irq_in),
        .chk_clr_out (chk_clr_out),
        .chk_ns_out  (chk_ns_out),
        .irq_out     (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] status_of(input logic [N-1:0] v);
        logic [31:0] w;
        w = 32'h0;
        for (int i = 0; i < N; i++) w[i+16] = v[i];
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h030: return status_of(chk_irq_in);
            12'h038: return m_en;
            12'h0D0: return m_ns;
            default: return 32'h0;
        endcase
    endfunction

    // Reference model update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en  <= 32'h0;
            m_ns  <= 32'h0;
            m_clr <= '0;
        end else if (reg_wr) begin
            case ({reg_addr[11:2], 2'b00})
                12'h038: m_en  <= reg_wdata;
                12'h0D0: m_ns  <= reg_wdata;
                12'h034: m_clr <= reg_wdata[16 +: N];
                default: ;
            endcase
        end
    end

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R3 irq_out", {31'h0, irq_out}, {31'h0, |(status_of(chk_irq_in) & m_en)});
            chk("R5 clear lines", {16'h0, chk_clr_out}, {16'h0, m_clr});
            chk("R6 ns lines", {16'h0, chk_ns_out}, {16'h0, m_ns[16 +: N]});
            chk("R1 R2 R4 R6 R8 read data", reg_rdata, exp_read(reg_addr));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [11:0] a);
        @(posedge clk); #2;
        reg_addr = a;
    endtask

    task automatic set_in(input logic [N-1:0] v);
        @(posedge clk); #2;
        chk_irq_in = v;
    endtask

    task automatic peek(input string tag, input logic [31:0] exp);
        @(negedge clk); #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        chk_irq_in = 16'hA5C3;
        @(posedge clk); #2;
        cmp_on = 1'b1;
        // R7: reset state, status still live.
        set_addr(12'h030);
        peek("R7 status tracks during reset", 32'hA5C3_0000);
        set_in(16'h0F0F);
        peek("R7 status follows change in reset", 32'h0F0F_0000);
        set_addr(12'h038); peek("R7 enable reset", 32'h0);
        set_addr(12'h0D0); peek("R7 nscfg reset", 32'h0);
        @(negedge clk); #1;
        chk("R7 clear lines reset", {16'h0, chk_clr_out}, 32'h0);
        chk("R7 irq low in reset", {31'h0, irq_out}, 32'h0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R4 and R3: enable all, interrupt follows inputs.
        wr(12'h038, 32'hFFFF_FFFF);
        set_addr(12'h038); peek("R4 enable readback", 32'hFFFF_FFFF);
        @(negedge clk); #1; chk("R3 irq with active inputs", {31'h0, irq_out}, 32'h1);
        set_in('0);
        @(negedge clk); #1; chk("R3 irq drops same cycle", {31'h0, irq_out}, 32'h0);
        set_in(16'h0100);
        @(negedge clk); #1; chk("R3 irq rises same cycle", {31'h0, irq_out}, 32'h1);
        wr(12'h038, 32'h0000_FFFF);
        @(negedge clk); #1; chk("R3 low enable bits inert", {31'h0, irq_out}, 32'h0);
        wr(12'h038, 32'h0100_0000);
        @(negedge clk); #1; chk("R3 matching enable bit", {31'h0, irq_out}, 32'h1);
        wr(12'h038, 32'h0200_0000);
        @(negedge clk); #1; chk("R3 non-matching enable bit", {31'h0, irq_out}, 32'h0);

        // R2: status write has no effect.
        wr(12'h030, 32'hFFFF_FFFF);
        set_addr(12'h031); peek("R2 R1 status after write", 32'h0100_0000);
        set_addr(12'h038); peek("R2 enable untouched", 32'h0200_0000);

        // R5: level clear lines.
        wr(12'h034, 32'h8001_1234);
        @(negedge clk); #1; chk("R5 clear lines set", {16'h0, chk_clr_out}, 32'h0000_8001);
        set_addr(12'h034); peek("R5 clear reads zero", 32'h0);
        wr(12'h038, 32'h1);
        @(negedge clk); #1; chk("R5 clear lines hold", {16'h0, chk_clr_out}, 32'h0000_8001);
        wr(12'h034, 32'h0000_FFFF);
        @(negedge clk); #1; chk("R5 clear lines released", {16'h0, chk_clr_out}, 32'h0);

        // R6: non-secure configuration.
        wr(12'h0D0, 32'h1234_5678);
        set_addr(12'h0D0); peek("R6 nscfg readback", 32'h1234_5678);
        @(negedge clk); #1; chk("R6 ns lines", {16'h0, chk_ns_out}, 32'h0000_1234);

        // R8: unmapped offsets.
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        set_addr(12'h03C); peek("R8 unmapped reads zero", 32'h0);
        set_addr(12'h0D0); peek("R8 nscfg untouched", 32'h1234_5678);
        set_addr(12'h038); peek("R8 enable untouched", 32'h1);

        // R7: mid-run reset with loaded registers.
        wr(12'h034, 32'hFFFF_0000);
        wr(12'h038, 32'hFFFF_0000);
        @(posedge clk); #2; rst_n = 1'b0; reg_addr = 12'h030;
        set_in(16'h5A5A);
        peek("R7 status live in mid reset", 32'h5A5A_0000);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R7 clear lines after reset", {16'h0, chk_clr_out}, 32'h0);
        chk("R7 ns lines after reset", {16'h0, chk_ns_out}, 32'h0);
        set_addr(12'h038); peek("R7 enable after reset", 32'h0);

        // Random mix compared every cycle by the model.
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #2;
            reg_wr = ($urandom % 3) != 0;
            case ($urandom % 6)
                0: reg_addr = 12'h030;
                1: reg_addr = 12'h034;
                2: reg_addr = 12'h038;
                3: reg_addr = 12'h0D0;
                4: reg_addr = 12'h03B;
                default: reg_addr = 12'($urandom);
            endcase
            reg_wdata = $urandom;
            if (($urandom % 4) == 0) chk_irq_in = N'($urandom);
        end
        @(posedge clk); #2; reg_wr = 1'b0;
        @(negedge clk); #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule